// File: doc/BRIEF.md
# Variable-Precision Radix-4 Butterfly Element

This block is one processing element of a transform array. Each cycle it can accept one four-point butterfly on complex fixed-point samples and produce the four transformed results six cycles later. The same hardware computes either the forward or the inverse transform, chosen per butterfly by a direction flag. The operand word length is chosen per butterfly from three settings: the full width, two bits narrower, or four bits narrower. A per-lane mask replaces chosen input samples with zero, so that a record shorter than a power of two can be padded out inside the element.

Twiddle factors are not generated here. They come in on dedicated ports from the element above in the array, and the element passes them on, one register later, to the element below. Every result is scaled by one quarter with rounding, so the values stay in range from one transform stage to the next. Results that still exceed the selected width are saturated.

Top module: `bfly4_pe`

## Requirements
- R1: A butterfly presented with `inValid` high at a rising edge appears on the outputs with `outValid` high exactly six rising edges later. A new butterfly may be presented at every edge, and `outValid` is low for every cycle in which no result is due.
- R2: In forward mode (`inInverse`=0), with a = x0, b = x1·w1, c = x2·w2 and d = x3·w3, the unscaled results are y0 = a+b+c+d, y1 = a−jb−c+jd, y2 = a−b+c−d and y3 = a+jb−c−jd. Lane n is element n of the packed sample ports, and twiddle element t applies to lane t+1.
- R3: In inverse mode (`inInverse`=1), each twiddle is used as its complex conjugate, and the ±j rotations are exchanged: y1 = a+jb−c−jd and y3 = a−jb−c+jd. y0 and y2 are the same as in R2.
- R4: Twiddles are signed fractions with TW−1 fractional bits. Each real and imaginary part of a twiddled product is formed from the exact cross-product sum as (s + 2^(TW−2)) >>> (TW−1).
- R5: Each output component is (y + 2^(k−1)) >>> k, where k = 2 + D and D is the number of dropped bits. The result is clamped to the signed range of DW−D bits and then shifted left by D to sit left-aligned in the DW-bit port.
- R6: `inWidth` encodes the word length: 0 selects DW bits (D=0), 1 selects DW−2 bits (D=2), and 2 or 3 selects DW−4 bits (D=4). The D least significant bits of every input sample are ignored, and the D least significant bits of every output are zero.
- R7: When bit n of `inPad` is set, input lane n is treated as zero, whatever the sample ports carry.
- R8: `twFwdRe`/`twFwdIm` carry the twiddle inputs delayed by exactly one rising edge, on every cycle and independent of `inValid`.
- R9: While `rst` is high (synchronous, active high), `outValid` is low and every output and forwarded twiddle is zero.
- R10: Sample, twiddle and mode inputs presented with `inValid` low have no effect. The result outputs hold their last value in every cycle in which `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A butterfly is presented this cycle |
| inInverse | input | 1 | 1 = inverse transform, 0 = forward |
| inWidth | input | 2 | Word-length select (see R6) |
| inPad | input | 4 | Per-lane zero-pad mask |
| inRe | input | 4×DW | Real parts of the four input samples |
| inIm | input | 4×DW | Imaginary parts of the four input samples |
| twRe | input | 3×TW | Real parts of twiddles for lanes 1..3 |
| twIm | input | 3×TW | Imaginary parts of twiddles for lanes 1..3 |
| outValid | output | 1 | Results on the outputs are new this cycle |
| outRe | output | 4×DW | Real parts of the four results |
| outIm | output | 4×DW | Imaginary parts of the four results |
| twFwdRe | output | 3×TW | Twiddle real parts forwarded to the next element |
| twFwdIm | output | 3×TW | Twiddle imaginary parts forwarded to the next element |

## Verification
The assertions assume that reset is applied synchronously for at least one edge before any butterfly is presented. They also assume that `inValid`, `inPad` and `inWidth` are driven to known values on every cycle, because the latency, padding and low-bit properties look back six edges at those inputs. The stimulus drives every input at the falling edge from the first cycle of reset onward and never leaves them undriven. It sweeps all width codes, both directions and all sixteen pad masks with extreme and pseudo-random samples. It also scatters idle cycles that carry non-zero data, so the hold rule is tested against inputs that would change the result if they were used.

// File: rtl/bfly4_pkg.sv
package bfly4_pkg;

  localparam int LANES = 4;
  localparam int TWIDS = LANES - 1;
  localparam int DEPTH = 6;

  // Stage load enables and mode bits aligned to the stage that consumes them
  typedef struct packed {
    logic [DEPTH-1:0] ld;
    logic             invS3;
    logic             invS5;
    logic [1:0]       wselS6;
  } bflyStrobe_t;

  // Number of low-order bits dropped for a width code
  function automatic int dropBits(input logic [1:0] wsel);
    case (wsel)
      2'd0:    return 0;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/bfly4_ctrl.sv
module bfly4_ctrl
  import bfly4_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        inInverse,
  input  logic [1:0]  inWidth,
  output bflyStrobe_t strobe,
  output logic        outValid
);

  logic [DEPTH-1:0] vldPipe;
  logic [DEPTH-1:0] invPipe;
  logic [1:0]       wselPipe [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      vldPipe <= '0;
      invPipe <= '0;
      for (int i = 0; i < DEPTH; i++) wselPipe[i] <= '0;
    end else begin
      vldPipe <= {vldPipe[DEPTH-2:0], inValid};
      invPipe <= {invPipe[DEPTH-2:0], inInverse};
      wselPipe[0] <= inWidth;
      for (int i = 1; i < DEPTH; i++) wselPipe[i] <= wselPipe[i-1];
    end
  end

  // Entry i describes the data held in stage register i+1
  always_comb begin
    strobe.ld     = {vldPipe[DEPTH-2:0], inValid};
    strobe.invS3  = invPipe[1];
    strobe.invS5  = invPipe[3];
    strobe.wselS6 = wselPipe[4];
  end

  assign outValid = vldPipe[DEPTH-1];

endmodule

// File: rtl/bfly4_dp.sv
module bfly4_dp
  import bfly4_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  bflyStrobe_t                  strobe,
  input  logic [LANES-1:0]             inPad,
  input  logic [1:0]                   inWidth,
  input  logic [LANES-1:0][DW-1:0]     inRe,
  input  logic [LANES-1:0][DW-1:0]     inIm,
  input  logic [TWIDS-1:0][TW-1:0]     twRe,
  input  logic [TWIDS-1:0][TW-1:0]     twIm,
  output logic [LANES-1:0][DW-1:0]     outRe,
  output logic [LANES-1:0][DW-1:0]     outIm,
  output logic [TWIDS-1:0][TW-1:0]     twFwdRe,
  output logic [TWIDS-1:0][TW-1:0]     twFwdIm
);

  localparam int MW = DW + TW;   // one real product
  localparam int AW = MW + 1;    // sum of two products
  localparam int RW = DW + 2;    // rounded twiddled sample
  localparam int SW = DW + 4;    // butterfly sums
  localparam int SX = SW + 1;    // quantizer headroom

  function automatic logic signed [DW-1:0] quantize(input logic signed [SW-1:0] v,
                                                     input logic [1:0] wsel);
    int drop;
    int sh;
    logic signed [SX-1:0] ext, half, r, hi, lo;
    drop = dropBits(wsel);
    sh   = 2 + drop;
    ext  = SX'(v);
    half = SX'(1) <<< (sh - 1);
    r    = (ext + half) >>> sh;
    hi   = (SX'(1) <<< (DW - 1 - drop)) - SX'(1);
    lo   = -(SX'(1) <<< (DW - 1 - drop));
    if (r > hi)      r = hi;
    else if (r < lo) r = lo;
    return DW'(r <<< drop);
  endfunction

  // ---------------- stage 1: pad, truncate to width, capture ----------------
  logic [DW-1:0]        keepMask;
  logic signed [DW-1:0] mRe [LANES];
  logic signed [DW-1:0] mIm [LANES];
  logic signed [DW-1:0] s1Re [LANES];
  logic signed [DW-1:0] s1Im [LANES];
  logic signed [TW-1:0] s1TwRe [TWIDS];
  logic signed [TW-1:0] s1TwIm [TWIDS];

  always_comb begin
    keepMask = {DW{1'b1}} << dropBits(inWidth);
    for (int n = 0; n < LANES; n++) begin
      mRe[n] = inPad[n] ? '0 : $signed(inRe[n] & keepMask);
      mIm[n] = inPad[n] ? '0 : $signed(inIm[n] & keepMask);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < LANES; n++) begin
        s1Re[n] <= '0;
        s1Im[n] <= '0;
      end
      for (int t = 0; t < TWIDS; t++) begin
        s1TwRe[t] <= '0;
        s1TwIm[t] <= '0;
      end
    end else if (strobe.ld[0]) begin
      for (int n = 0; n < LANES; n++) begin
        s1Re[n] <= mRe[n];
        s1Im[n] <= mIm[n];
      end
      for (int t = 0; t < TWIDS; t++) begin
        s1TwRe[t] <= $signed(twRe[t]);
        s1TwIm[t] <= $signed(twIm[t]);
      end
    end
  end

  // Twiddle pass-through to the neighbouring element, loaded every cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      twFwdRe <= '0;
      twFwdIm <= '0;
    end else begin
      twFwdRe <= twRe;
      twFwdIm <= twIm;
    end
  end

  // ---------------- lane 0 bypasses the multipliers ----------------
  logic signed [DW-1:0] s2ARe, s2AIm;
  logic signed [RW-1:0] s3Re [LANES];
  logic signed [RW-1:0] s3Im [LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      s2ARe <= '0;
      s2AIm <= '0;
    end else if (strobe.ld[1]) begin
      s2ARe <= s1Re[0];
      s2AIm <= s1Im[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s3Re[0] <= '0;
      s3Im[0] <= '0;
    end else if (strobe.ld[2]) begin
      s3Re[0] <= RW'(s2ARe);
      s3Im[0] <= RW'(s2AIm);
    end
  end

  // ---------------- stages 2-3: twiddle multiply per lane ----------------
  for (genvar t = 0; t < TWIDS; t++) begin : gTwid
    logic signed [MW-1:0] pRR, pII, pRI, pIR;
    logic signed [AW-1:0] sumRe, sumIm, rndRe, rndIm;

    always_ff @(posedge clk) begin
      if (rst) begin
        pRR <= '0;
        pII <= '0;
        pRI <= '0;
        pIR <= '0;
      end else if (strobe.ld[1]) begin
        pRR <= MW'(s1Re[t+1]) * MW'(s1TwRe[t]);
        pII <= MW'(s1Im[t+1]) * MW'(s1TwIm[t]);
        pRI <= MW'(s1Re[t+1]) * MW'(s1TwIm[t]);
        pIR <= MW'(s1Im[t+1]) * MW'(s1TwRe[t]);
      end
    end

    always_comb begin
      if (strobe.invS3) begin
        sumRe = AW'(pRR) + AW'(pII);
        sumIm = AW'(pIR) - AW'(pRI);
      end else begin
        sumRe = AW'(pRR) - AW'(pII);
        sumIm = AW'(pIR) + AW'(pRI);
      end
      rndRe = (sumRe + (AW'(1) <<< (TW - 2))) >>> (TW - 1);
      rndIm = (sumIm + (AW'(1) <<< (TW - 2))) >>> (TW - 1);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        s3Re[t+1] <= '0;
        s3Im[t+1] <= '0;
      end else if (strobe.ld[2]) begin
        s3Re[t+1] <= RW'(rndRe);
        s3Im[t+1] <= RW'(rndIm);
      end
    end
  end

  // ---------------- stage 4: first adder level ----------------
  // index 0: a+c, 1: a-c, 2: b+d, 3: b-d
  logic signed [SW-1:0] s4Re [LANES];
  logic signed [SW-1:0] s4Im [LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < LANES; n++) begin
        s4Re[n] <= '0;
        s4Im[n] <= '0;
      end
    end else if (strobe.ld[3]) begin
      s4Re[0] <= SW'(s3Re[0]) + SW'(s3Re[2]);
      s4Im[0] <= SW'(s3Im[0]) + SW'(s3Im[2]);
      s4Re[1] <= SW'(s3Re[0]) - SW'(s3Re[2]);
      s4Im[1] <= SW'(s3Im[0]) - SW'(s3Im[2]);
      s4Re[2] <= SW'(s3Re[1]) + SW'(s3Re[3]);
      s4Im[2] <= SW'(s3Im[1]) + SW'(s3Im[3]);
      s4Re[3] <= SW'(s3Re[1]) - SW'(s3Re[3]);
      s4Im[3] <= SW'(s3Im[1]) - SW'(s3Im[3]);
    end
  end

  // ---------------- stage 5: second level with ±j rotation ----------------
  logic signed [SW-1:0] s5Re [LANES];
  logic signed [SW-1:0] s5Im [LANES];
  logic signed [SW-1:0] negJRe, negJIm, posJRe, posJIm;

  always_comb begin
    // (a-c) - j(b-d) and (a-c) + j(b-d)
    negJRe = s4Re[1] + s4Im[3];
    negJIm = s4Im[1] - s4Re[3];
    posJRe = s4Re[1] - s4Im[3];
    posJIm = s4Im[1] + s4Re[3];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < LANES; n++) begin
        s5Re[n] <= '0;
        s5Im[n] <= '0;
      end
    end else if (strobe.ld[4]) begin
      s5Re[0] <= s4Re[0] + s4Re[2];
      s5Im[0] <= s4Im[0] + s4Im[2];
      s5Re[2] <= s4Re[0] - s4Re[2];
      s5Im[2] <= s4Im[0] - s4Im[2];
      s5Re[1] <= strobe.invS5 ? posJRe : negJRe;
      s5Im[1] <= strobe.invS5 ? posJIm : negJIm;
      s5Re[3] <= strobe.invS5 ? negJRe : posJRe;
      s5Im[3] <= strobe.invS5 ? negJIm : posJIm;
    end
  end

  // ---------------- stage 6: scale, round, saturate, realign ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      outRe <= '0;
      outIm <= '0;
    end else if (strobe.ld[5]) begin
      for (int n = 0; n < LANES; n++) begin
        outRe[n] <= quantize(s5Re[n], strobe.wselS6);
        outIm[n] <= quantize(s5Im[n], strobe.wselS6);
      end
    end
  end

endmodule

// File: rtl/bfly4_pe.sv
module bfly4_pe
  import bfly4_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic                     inInverse,
  input  logic [1:0]               inWidth,
  input  logic [3:0]               inPad,
  input  logic [3:0][DW-1:0]       inRe,
  input  logic [3:0][DW-1:0]       inIm,
  input  logic [2:0][TW-1:0]       twRe,
  input  logic [2:0][TW-1:0]       twIm,
  output logic                     outValid,
  output logic [3:0][DW-1:0]       outRe,
  output logic [3:0][DW-1:0]       outIm,
  output logic [2:0][TW-1:0]       twFwdRe,
  output logic [2:0][TW-1:0]       twFwdIm
);

  bflyStrobe_t strobe;

  bfly4_ctrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inInverse (inInverse),
    .inWidth   (inWidth),
    .strobe    (strobe),
    .outValid  (outValid)
  );

  bfly4_dp #(.DW(DW), .TW(TW)) uDp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .inPad   (inPad),
    .inWidth (inWidth),
    .inRe    (inRe),
    .inIm    (inIm),
    .twRe    (twRe),
    .twIm    (twIm),
    .outRe   (outRe),
    .outIm   (outIm),
    .twFwdRe (twFwdRe),
    .twFwdIm (twFwdIm)
  );

endmodule

// File: rtl/bfly4_pe_chk.sv
module bfly4_pe_chk #(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic [1:0]         inWidth,
  input logic [3:0]         inPad,
  input logic [2:0][TW-1:0] twRe,
  input logic [2:0][TW-1:0] twIm,
  input logic               outValid,
  input logic [3:0][DW-1:0] outRe,
  input logic [3:0][DW-1:0] outIm,
  input logic [2:0][TW-1:0] twFwdRe,
  input logic [2:0][TW-1:0] twFwdIm
);

  logic [2:0] sinceRst;
  logic       lowBitsSet;

  always_ff @(posedge clk) begin
    if (rst)                sinceRst <= '0;
    else if (sinceRst != 7) sinceRst <= sinceRst + 3'd1;
  end

  always_comb begin
    lowBitsSet = 1'b0;
    for (int n = 0; n < 4; n++)
      lowBitsSet = lowBitsSet | (|outRe[n][1:0]) | (|outIm[n][1:0]);
  end

  AST_LATENCY_SIX: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 3'd6) |-> (outValid == $past(inValid, 6))); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> ($stable(outRe) && $stable(outIm))); // R10

  AST_PAD_ALL_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((sinceRst >= 3'd6) && $past(inValid && (&inPad), 6))
      |-> (outValid && (outRe == '0) && (outIm == '0))); // R7

  AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((sinceRst >= 3'd6) && outValid && ($past(inWidth, 6) != 2'd0))
      |-> !lowBitsSet); // R6

  AST_TW_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 3'd1) |-> ((twFwdRe == $past(twRe)) && (twFwdIm == $past(twIm)))); // R8

endmodule

bind bfly4_pe bfly4_pe_chk #(.DW(DW), .TW(TW)) uChk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inWidth  (inWidth),
  .inPad    (inPad),
  .twRe     (twRe),
  .twIm     (twIm),
  .outValid (outValid),
  .outRe    (outRe),
  .outIm    (outIm),
  .twFwdRe  (twFwdRe),
  .twFwdIm  (twFwdIm)
);

// File: tb/bfly4_pe_test.sv
module bfly4_pe_test;

  localparam int DW = 16;
  localparam int TW = 16;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 inValid = 1'b0;
  logic                 inInverse = 1'b0;
  logic [1:0]           inWidth = '0;
  logic [3:0]           inPad = '0;
  logic [3:0][DW-1:0]   inRe = '0;
  logic [3:0][DW-1:0]   inIm = '0;
  logic [2:0][TW-1:0]   twRe = '0;
  logic [2:0][TW-1:0]   twIm = '0;
  logic                 outValid;
  logic [3:0][DW-1:0]   outRe, outIm;
  logic [2:0][TW-1:0]   twFwdRe, twFwdIm;

  always #10 clk = ~clk;

  bfly4_pe #(.DW(DW), .TW(TW)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inInverse(inInverse),
    .inWidth(inWidth), .inPad(inPad), .inRe(inRe), .inIm(inIm),
    .twRe(twRe), .twIm(twIm), .outValid(outValid), .outRe(outRe),
    .outIm(outIm), .twFwdRe(twFwdRe), .twFwdIm(twFwdIm)
  );

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;
  bit done = 0;
  bit [31:0] seed = 32'h1234_5679;

  logic [3:0][DW-1:0] expRe [8];
  logic [3:0][DW-1:0] expIm [8];
  bit                 expV  [8];
  string              expTag[8];
  logic [3:0][DW-1:0] lastRe = '0, lastIm = '0;
  logic [2:0][TW-1:0] prevTwRe = '0, prevTwIm = '0;

  task automatic check(input bit ok, input string tag, input string detail);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: %s", tag, detail);
    end
  endtask

  function automatic bit [31:0] nextRand(input bit [31:0] s);
    bit [31:0] v = s;
    v ^= v << 13;
    v ^= v >> 17;
    v ^= v << 5;
    return v;
  endfunction

  // R5: scale by a quarter and drop D bits with rounding, clamp, realign
  function automatic longint quantRef(input longint v, input int drop);
    int sh = 2 + drop;
    longint r, hi, lo;
    r  = (v + (longint'(1) <<< (sh - 1))) >>> sh;
    hi = (longint'(1) <<< (DW - 1 - drop)) - 1;
    lo = -hi - 1;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r <<< drop;
  endfunction

  function automatic void model(input logic [3:0][DW-1:0] xr, input logic [3:0][DW-1:0] xi,
                                input logic [2:0][TW-1:0] wr, input logic [2:0][TW-1:0] wi,
                                input logic [3:0] pad, input logic [1:0] ws, input bit inv,
                                output logic [3:0][DW-1:0] yr, output logic [3:0][DW-1:0] yi);
    int drop = (ws == 2'd0) ? 0 : (ws == 2'd1) ? 2 : 4;       // R6
    longint ar[4], ai[4], vr[4], vi[4], zr[4], zi[4];
    for (int n = 0; n < 4; n++) begin                           // R7
      ar[n] = pad[n] ? 0 : ((longint'($signed(xr[n])) >>> drop) <<< drop);
      ai[n] = pad[n] ? 0 : ((longint'($signed(xi[n])) >>> drop) <<< drop);
    end
    vr[0] = ar[0];
    vi[0] = ai[0];
    for (int t = 1; t < 4; t++) begin                           // R4
      longint cr = longint'($signed(wr[t-1]));
      longint ci = longint'($signed(wi[t-1]));
      longint sr, si;
      if (inv) begin
        sr = ar[t] * cr + ai[t] * ci;
        si = ai[t] * cr - ar[t] * ci;
      end else begin
        sr = ar[t] * cr - ai[t] * ci;
        si = ai[t] * cr + ar[t] * ci;
      end
      vr[t] = (sr + 16384) >>> 15;
      vi[t] = (si + 16384) >>> 15;
    end
    zr[0] = vr[0] + vr[1] + vr[2] + vr[3];
    zi[0] = vi[0] + vi[1] + vi[2] + vi[3];
    zr[2] = vr[0] - vr[1] + vr[2] - vr[3];
    zi[2] = vi[0] - vi[1] + vi[2] - vi[3];
    // a - jb - c + jd
    zr[1] = vr[0] + vi[1] - vr[2] - vi[3];
    zi[1] = vi[0] - vr[1] - vi[2] + vr[3];
    // a + jb - c - jd
    zr[3] = vr[0] - vi[1] - vr[2] + vi[3];
    zi[3] = vi[0] + vr[1] - vi[2] - vr[3];
    if (inv) begin                                              // R3
      longint tr = zr[1], ti = zi[1];
      zr[1] = zr[3]; zi[1] = zi[3];
      zr[3] = tr;    zi[3] = ti;
    end
    for (int k = 0; k < 4; k++) begin
      longint qr = quantRef(zr[k], drop);
      longint qi = quantRef(zi[k], drop);
      yr[k] = qr[DW-1:0];
      yi[k] = qi[DW-1:0];
    end
  endfunction

  task automatic tick(input bit v, input logic [3:0][DW-1:0] xr, input logic [3:0][DW-1:0] xi,
                      input logic [2:0][TW-1:0] wr, input logic [2:0][TW-1:0] wi,
                      input logic [3:0] pad, input logic [1:0] ws, input bit inv);
    int cs, ns;
    logic [3:0][DW-1:0] yr, yi;
    @(negedge clk);
    cs = (cyc + 2) % 8;
    ns = cyc % 8;
    check(outValid === expV[cs], "R1",
          $sformatf("outValid=%0b expected %0b at cycle %0d", outValid, expV[cs], cyc));
    if (expV[cs]) begin
      check((outRe === expRe[cs]) && (outIm === expIm[cs]), expTag[cs],
            $sformatf("re=%h im=%h expected re=%h im=%h", outRe, outIm, expRe[cs], expIm[cs]));
      lastRe = expRe[cs];
      lastIm = expIm[cs];
    end else begin
      check((outRe === lastRe) && (outIm === lastIm), "R10",
            $sformatf("idle re=%h im=%h expected held re=%h im=%h", outRe, outIm, lastRe, lastIm));
    end
    check((twFwdRe === prevTwRe) && (twFwdIm === prevTwIm), "R8",
          $sformatf("twFwd re=%h im=%h expected re=%h im=%h", twFwdRe, twFwdIm, prevTwRe, prevTwIm));
    prevTwRe = wr;
    prevTwIm = wi;
    inValid = v; inRe = xr; inIm = xi; twRe = wr; twIm = wi;
    inPad = pad; inWidth = ws; inInverse = inv;
    model(xr, xi, wr, wi, pad, ws, inv, yr, yi);
    expV[ns]   = v;
    expRe[ns]  = yr;
    expIm[ns]  = yi;
    expTag[ns] = $sformatf("%s R4 R5%s%s", inv ? "R3" : "R2",
                           (ws != 2'd0) ? " R6" : "", (pad != 4'd0) ? " R7" : "");
    cyc++;
  endtask

  initial begin
    logic [3:0][DW-1:0] xr, xi;
    logic [2:0][TW-1:0] wr, wi;
    for (int i = 0; i < 8; i++) begin
      expV[i] = 0; expRe[i] = '0; expIm[i] = '0; expTag[i] = "R1";
    end
    repeat (3) @(negedge clk);
    check((outValid === 1'b0) && (outRe === '0) && (outIm === '0) &&
          (twFwdRe === '0) && (twFwdIm === '0), "R9",
          $sformatf("in reset valid=%0b re=%h im=%h expected all zero", outValid, outRe, outIm));
    rst = 1'b0;

    for (int ws = 0; ws < 4; ws++) begin
      for (int inv = 0; inv < 2; inv++) begin
        for (int pad = 0; pad < 16; pad++) begin
          for (int rep = 0; rep < 4; rep++) begin
            for (int n = 0; n < 4; n++) begin
              seed = nextRand(seed); xr[n] = seed[15:0]; xi[n] = seed[31:16];
            end
            for (int t = 0; t < 3; t++) begin
              seed = nextRand(seed); wr[t] = seed[15:0]; wi[t] = seed[31:16];
            end
            if (rep == 0) begin                 // saturating extreme, R5
              xr = {4{16'h7FFF}}; xi = {4{16'h7FFF}};
              wr = {3{16'h7FFF}}; wi = {3{16'h8000}};
            end else if (rep == 1) begin        // most negative operands, R4
              xr = {4{16'h8000}}; xi = {4{16'h8000}};
              wr = {3{16'h8000}}; wi = {3{16'h8000}};
            end
            if ((pad % 5 == 2) && (rep == 3))   // idle slot carrying data, R10
              tick(1'b0, xr, xi, wr, wi, pad[3:0], ws[1:0], inv[0]);
            tick(1'b1, xr, xi, wr, wi, pad[3:0], ws[1:0], inv[0]);
          end
        end
      end
    end
    for (int i = 0; i < 8; i++) begin
      seed = nextRand(seed);
      tick(1'b0, {2{seed}}, {2{~seed}}, {seed, seed[15:0]}, {seed[15:0], seed}, 4'h0, 2'd0, 1'b0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: run did not complete, expected completion before 200000 cycles");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

endmodule